// File: doc/BRIEF.md
# Serial DAC Link Startup Sequencer

This block runs the transmit side of the startup of a multi-lane serial link to a DAC. For every lane it picks the symbol handed to the downstream encoder: nothing while the link is held in reset, the comma character during code group synchronization, a marked alignment sequence, and then payload bytes. It follows an enable, the receiver's active-low SYNC request and the local multiframe boundary pulse. It also reports its phase on a 2-bit state output.

The transmitter does not wait for a lock indication before it sends commas, because the serializer PLL locks on the reference clock alone. A hold input keeps the link in the comma phase and ignores SYNC, so alignment on the receiver can be checked without the sequencer going on to the alignment sequence.

One symbol per lane per clock is produced, as an 8-bit byte plus a control-character flag. Each frame takes one clock and each multiframe takes `MF_LEN` frames.

Top module: `lane_link_sequencer`

## Requirements
- R1: While `rst` is high, or on the cycle after any clock edge at which `en` is low, `link_state` is 2'b00, `link_rst` is 1, and every lane byte and control flag is 0.
- R2: At the first edge with `en` high in the reset phase, `link_state` becomes 2'b01 (CGS). Every lane then sends byte 0xBC with its control flag set, and no lock input is waited for.
- R3: `sync_n` passes through two flip-flops before it is used. A rise of `sync_n` seen at an edge cannot start the alignment sequence at that edge or at the next edge.
- R4: The CGS phase is left only at an edge where `lmfc_tick` is high, the synchronized SYNC is high (released) and `hold_cgs` is low. The sequence does not start at the release itself.
- R5: While `hold_cgs` is high, the sequencer stays in CGS whatever the level of `sync_n`.
- R6: The alignment phase (`link_state` 2'b10) lasts exactly 4*MF_LEN cycles and sends the same symbols on all lanes. In each multiframe the first symbol is 0x1C with the control flag set and the last is 0x7C with the control flag set. The symbols between them are the sequence index modulo 256 with the control flag clear.
- R7: After the alignment phase the state becomes 2'b11 (DATA). Lane i then sends byte i of `payload` as it was sampled at the previous edge, with the control flag clear.
- R8: In the alignment or DATA phase, LOSS_CYCLES consecutive cycles of low synchronized SYNC return the sequencer to CGS. Shorter low bursts do not affect it.
- R9: `link_state` and the lane symbols are registered together, so the symbols of a phase appear on the cycle in which the state output first shows that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one frame per cycle |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Link enable; low holds the link in reset |
| hold_cgs | input | 1 | Keep the link in the comma phase and ignore SYNC |
| sync_n | input | 1 | Receiver SYNC request, active low, asynchronous |
| lmfc_tick | input | 1 | One-cycle pulse at each local multiframe boundary |
| payload | input | LANES*8 | User data, byte i for lane i |
| lane_data | output | LANES*8 | Symbol byte per lane |
| lane_ctrl | output | LANES | Control-character flag per lane |
| link_state | output | 2 | 00 reset, 01 CGS, 10 alignment, 11 DATA |
| link_rst | output | 1 | Reset for the physical, link and transport stages |

## Verification
The embedded properties check on every cycle that a low enable forces the reset phase, that hold keeps CGS, and that the alignment phase is entered only from CGS at a boundary with SYNC released. They also check that DATA follows only the alignment phase, that a return to CGS needs a low SYNC, and that the state and lane symbols agree in the comma and reset phases. The bench's scenarios are needed for the rest: the exact length and marker placement of the alignment sequence, the two-flop delay on SYNC, the difference between a short and a long SYNC loss, and the one-cycle payload latency. A behavioural model compares every output on every cycle against those scenarios.

// File: rtl/lls_pkg.sv
package lls_pkg;
  typedef enum logic [1:0] {
    ST_RST  = 2'b00,
    ST_CGS  = 2'b01,
    ST_ILAS = 2'b10,
    ST_DATA = 2'b11
  } link_st_e;

  localparam logic [7:0] SYM_COMMA = 8'hBC;  // K28.5
  localparam logic [7:0] SYM_MSTART = 8'h1C; // K28.0
  localparam logic [7:0] SYM_MEND = 8'h7C;   // K28.3
endpackage

// File: rtl/lls_sync2.sv
module lls_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/lls_fsm.sv
module lls_fsm
  import lls_pkg::*;
#(
  parameter int MF_LEN      = 16,
  parameter int ILAS_MF     = 4,
  parameter int LOSS_CYCLES = 8,
  localparam int ILAS_LEN   = MF_LEN * ILAS_MF,
  localparam int IW         = (ILAS_LEN > 1) ? $clog2(ILAS_LEN) : 1,
  localparam int FW         = (MF_LEN > 1) ? $clog2(MF_LEN) : 1,
  localparam int LW         = $clog2(LOSS_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          hold,
  input  logic          sync_ok,
  input  logic          tick,
  output link_st_e      st_q,
  output link_st_e      st_d,
  output logic [FW-1:0] frm_d,
  output logic [IW-1:0] idx_d
);
  logic [IW-1:0] idx_q;
  logic [FW-1:0] frm_q;
  logic [LW-1:0] low_q, low_d;
  logic          in_link, lost;

  assign in_link = (st_q == ST_ILAS) || (st_q == ST_DATA);
  assign lost    = in_link && !sync_ok && (low_q == LW'(LOSS_CYCLES - 1));

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    frm_d = frm_q;
    low_d = (in_link && !sync_ok) ? low_q + LW'(1) : '0;
    unique case (st_q)
      ST_RST: st_d = ST_CGS;
      ST_CGS: begin
        if (tick && sync_ok && !hold) begin
          st_d  = ST_ILAS;
          idx_d = '0;
          frm_d = '0;
        end
      end
      ST_ILAS: begin
        if (lost) st_d = ST_CGS;
        else if (idx_q == IW'(ILAS_LEN - 1)) st_d = ST_DATA;
        else begin
          idx_d = idx_q + IW'(1);
          frm_d = (frm_q == FW'(MF_LEN - 1)) ? '0 : frm_q + FW'(1);
        end
      end
      ST_DATA: if (lost) st_d = ST_CGS;
      default: st_d = ST_RST;
    endcase
    if (!en) st_d = ST_RST;
    if (lost || !en) low_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RST;
      idx_q <= '0;
      frm_q <= '0;
      low_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      frm_q <= frm_d;
      low_q <= low_d;
    end
  end

  AST_EN_LOW_RESETS: assert property (@(posedge clk) disable iff (rst)
    !en |=> st_q == ST_RST); // R1
  AST_HOLD_KEEPS_CGS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CGS && hold && en) |=> st_q == ST_CGS); // R5
  AST_ILAS_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ILAS && $past(st_q) != ST_ILAS) |->
      ($past(st_q) == ST_CGS && $past(tick) && $past(sync_ok) && !$past(hold))); // R4
  AST_DATA_AFTER_ILAS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && $past(st_q) != ST_DATA) |-> $past(st_q) == ST_ILAS); // R7
  AST_LOSS_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CGS && ($past(st_q) == ST_ILAS || $past(st_q) == ST_DATA)) |->
      !$past(sync_ok)); // R8
endmodule

// File: rtl/lls_lane_mux.sv
module lls_lane_mux
  import lls_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int MF_LEN    = 16,
  parameter int ILAS_MF   = 4,
  localparam int ILAS_LEN = MF_LEN * ILAS_MF,
  localparam int IW       = (ILAS_LEN > 1) ? $clog2(ILAS_LEN) : 1,
  localparam int FW       = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  link_st_e           st_d,
  input  logic [FW-1:0]      frm_d,
  input  logic [IW-1:0]      idx_d,
  input  logic [LANES*8-1:0] payload,
  output logic [LANES*8-1:0] lane_data,
  output logic [LANES-1:0]   lane_ctrl
);
  logic [7:0] ilas_byte;
  logic       ilas_ctrl;

  always_comb begin
    if (frm_d == '0) begin
      ilas_byte = SYM_MSTART;
      ilas_ctrl = 1'b1;
    end else if (frm_d == FW'(MF_LEN - 1)) begin
      ilas_byte = SYM_MEND;
      ilas_ctrl = 1'b1;
    end else begin
      ilas_byte = 8'(idx_d);
      ilas_ctrl = 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_data[g*8 +: 8] <= '0;
        lane_ctrl[g]        <= 1'b0;
      end else begin
        unique case (st_d)
          ST_CGS: begin
            lane_data[g*8 +: 8] <= SYM_COMMA;
            lane_ctrl[g]        <= 1'b1;
          end
          ST_ILAS: begin
            lane_data[g*8 +: 8] <= ilas_byte;
            lane_ctrl[g]        <= ilas_ctrl;
          end
          ST_DATA: begin
            lane_data[g*8 +: 8] <= payload[g*8 +: 8];
            lane_ctrl[g]        <= 1'b0;
          end
          default: begin
            lane_data[g*8 +: 8] <= '0;
            lane_ctrl[g]        <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/lane_link_sequencer.sv
module lane_link_sequencer
  import lls_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int MF_LEN      = 16,
  parameter int ILAS_MF     = 4,
  parameter int LOSS_CYCLES = 8,
  localparam int ILAS_LEN   = MF_LEN * ILAS_MF,
  localparam int IW         = (ILAS_LEN > 1) ? $clog2(ILAS_LEN) : 1,
  localparam int FW         = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               hold_cgs,
  input  logic               sync_n,
  input  logic               lmfc_tick,
  input  logic [LANES*8-1:0] payload,
  output logic [LANES*8-1:0] lane_data,
  output logic [LANES-1:0]   lane_ctrl,
  output logic [1:0]         link_state,
  output logic               link_rst
);
  logic          sync_ok;
  link_st_e      st_q, st_d;
  logic [FW-1:0] frm_d;
  logic [IW-1:0] idx_d;

  lls_sync2 #(.RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst(rst), .d(sync_n), .q(sync_ok)
  );

  lls_fsm #(.MF_LEN(MF_LEN), .ILAS_MF(ILAS_MF), .LOSS_CYCLES(LOSS_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .en(en), .hold(hold_cgs), .sync_ok(sync_ok),
    .tick(lmfc_tick), .st_q(st_q), .st_d(st_d), .frm_d(frm_d), .idx_d(idx_d)
  );

  lls_lane_mux #(.LANES(LANES), .MF_LEN(MF_LEN), .ILAS_MF(ILAS_MF)) u_mux (
    .clk(clk), .rst(rst), .st_d(st_d), .frm_d(frm_d), .idx_d(idx_d),
    .payload(payload), .lane_data(lane_data), .lane_ctrl(lane_ctrl)
  );

  assign link_state = st_q;
  assign link_rst   = (st_q == ST_RST);

  AST_RST_SILENT: assert property (@(posedge clk) disable iff (rst)
    (link_state == ST_RST) |-> (lane_ctrl == '0 && lane_data == '0)); // R1
  AST_CGS_COMMA: assert property (@(posedge clk) disable iff (rst)
    (link_state == ST_CGS) |-> (lane_ctrl == '1 && lane_data == {LANES{SYM_COMMA}})); // R9
  AST_DATA_NO_CTRL: assert property (@(posedge clk) disable iff (rst)
    (link_state == ST_DATA) |-> lane_ctrl == '0); // R7
endmodule

// File: tb/lane_link_sequencer_bench.sv
module lane_link_sequencer_bench;
  localparam int LANES = 4;
  localparam int MF_LEN = 16;
  localparam int ILAS_MF = 4;
  localparam int LOSS = 8;
  localparam int ILAS_LEN = MF_LEN * ILAS_MF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic hold_cgs = 1'b0;
  logic sync_n = 1'b0;
  logic lmfc_tick = 1'b0;
  logic [LANES*8-1:0] payload = '0;
  logic [LANES*8-1:0] lane_data;
  logic [LANES-1:0] lane_ctrl;
  logic [1:0] link_state;
  logic link_rst;

  int total = 0;
  int bad = 0;
  int tcnt = 0;
  int pcnt = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  lane_link_sequencer #(.LANES(LANES), .MF_LEN(MF_LEN), .ILAS_MF(ILAS_MF), .LOSS_CYCLES(LOSS))
    u_lane_link_sequencer (
      .clk(clk), .rst(rst), .en(en), .hold_cgs(hold_cgs), .sync_n(sync_n),
      .lmfc_tick(lmfc_tick), .payload(payload), .lane_data(lane_data),
      .lane_ctrl(lane_ctrl), .link_state(link_state), .link_rst(link_rst));

  // behavioural reference model
  int m_st = 0, m_idx = 0, m_low = 0;
  bit m_s1 = 0, m_s2 = 0;
  logic [LANES*8-1:0] e_data = '0;
  logic [LANES-1:0] e_ctrl = '0;
  logic [LANES*8-1:0] pay_prev = '0;
  bit tick_seen = 0;

  always @(posedge clk) begin
    bit lost, inlink;
    int nst, nidx, nlow, frm;
    tick_seen = lmfc_tick;
    pay_prev = payload;
    if (rst) begin
      m_st = 0; m_idx = 0; m_low = 0; m_s1 = 0; m_s2 = 0;
      e_data = '0; e_ctrl = '0;
    end else begin
      inlink = (m_st >= 2);
      lost = inlink && !m_s2 && (m_low == LOSS - 1);
      nlow = (inlink && !m_s2) ? m_low + 1 : 0;
      nst = m_st; nidx = m_idx;
      case (m_st)
        0: nst = 1;
        1: if (lmfc_tick && m_s2 && !hold_cgs) begin nst = 2; nidx = 0; end
        2: if (lost) nst = 1; else if (m_idx == ILAS_LEN - 1) nst = 3; else nidx = m_idx + 1;
        default: if (lost) nst = 1;
      endcase
      if (!en) nst = 0;
      if (lost || !en) nlow = 0;
      m_s2 = m_s1; m_s1 = sync_n;
      m_st = nst; m_idx = nidx; m_low = nlow;
      frm = m_idx % MF_LEN;
      for (int l = 0; l < LANES; l++) begin
        case (m_st)
          0: begin e_data[l*8 +: 8] = 8'h00; e_ctrl[l] = 1'b0; end
          1: begin e_data[l*8 +: 8] = 8'hBC; e_ctrl[l] = 1'b1; end
          2: begin
            if (frm == 0) begin e_data[l*8 +: 8] = 8'h1C; e_ctrl[l] = 1'b1; end
            else if (frm == MF_LEN - 1) begin e_data[l*8 +: 8] = 8'h7C; e_ctrl[l] = 1'b1; end
            else begin e_data[l*8 +: 8] = 8'(m_idx % 256); e_ctrl[l] = 1'b0; end
          end
          default: begin e_data[l*8 +: 8] = payload[l*8 +: 8]; e_ctrl[l] = 1'b0; end
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    string tag;
    tag = (m_st == 0) ? "R1" : (m_st == 1) ? "R2" : (m_st == 2) ? "R6" : "R7";
    check(link_state == 2'(m_st), "R9", "model state", 64'(link_state), 64'(m_st));
    check(lane_data == e_data, tag, "model lane_data", 64'(lane_data), 64'(e_data));
    check(lane_ctrl == e_ctrl, tag, "model lane_ctrl", 64'(lane_ctrl), 64'(e_ctrl));
    check(link_rst == (m_st == 0), "R1", "model link_rst", 64'(link_rst), 64'(m_st == 0));
  endtask

  task automatic step();
    @(negedge clk);
    compare_model();
    if (!rst) begin
      tcnt = (tcnt + 1) % MF_LEN;
      lmfc_tick = (tcnt == 0);
    end
    pcnt++;
    for (int l = 0; l < LANES; l++) payload[l*8 +: 8] = 8'(pcnt * 7 + l * 41);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int ilas_cycles;
    repeat (3) step();
    check(link_state == 2'b00 && lane_ctrl == '0 && link_rst, "R1", "in reset",
          64'(link_state), 64'h0);
    rst = 1'b0;
    repeat (5) step();
    check(link_state == 2'b00 && lane_data == '0 && link_rst, "R1", "enable low",
          64'(link_state), 64'h0);
    en = 1'b1;
    step();
    check(link_state == 2'b01, "R2", "CGS after enable", 64'(link_state), 64'h1);
    check(lane_data == {LANES{8'hBC}} && lane_ctrl == '1, "R2", "comma on all lanes",
          64'(lane_data), 64'hBCBCBCBC);
    hold_cgs = 1'b1;
    sync_n = 1'b1;
    repeat (3 * MF_LEN) step();
    check(link_state == 2'b01, "R5", "hold keeps CGS", 64'(link_state), 64'h1);
    // drop sync, release hold, raise sync just before a boundary edge
    sync_n = 1'b0;
    hold_cgs = 1'b0;
    n = 0;
    do begin step(); n++; end while (!lmfc_tick && n < 100);
    sync_n = 1'b1;
    step();
    check(link_state == 2'b01, "R3", "sync delay blocks start", 64'(link_state), 64'h1);
    n = 0;
    while (link_state == 2'b01 && n < 100) begin step(); n++; end
    check(link_state == 2'b10 && tick_seen, "R4", "ILAS starts at boundary",
          64'(link_state), 64'h2);
    check(lane_data[7:0] == 8'h1C && lane_ctrl == '1, "R6", "first ILAS marker",
          64'(lane_data[7:0]), 64'h1C);
    ilas_cycles = 1;
    while (link_state == 2'b10 && ilas_cycles < 500) begin
      step();
      if (ilas_cycles == MF_LEN - 1)
        check(lane_data[31:24] == 8'h7C && lane_ctrl == '1, "R6", "end marker",
              64'(lane_data[31:24]), 64'h7C);
      if (link_state == 2'b10) ilas_cycles++;
    end
    check(ilas_cycles == ILAS_LEN, "R6", "ILAS length", 64'(ilas_cycles), 64'(ILAS_LEN));
    check(link_state == 2'b11, "R7", "DATA after ILAS", 64'(link_state), 64'h3);
    step();
    check(lane_data == pay_prev && lane_ctrl == '0, "R7", "payload passthrough",
          64'(lane_data), 64'(pay_prev));
    sync_n = 1'b0;
    repeat (LOSS - 2) step();
    sync_n = 1'b1;
    repeat (6) step();
    check(link_state == 2'b11, "R8", "short loss ignored", 64'(link_state), 64'h3);
    sync_n = 1'b0;
    repeat (LOSS + 4) step();
    check(link_state == 2'b01, "R8", "long loss to CGS", 64'(link_state), 64'h1);
    sync_n = 1'b1;
    repeat (2 * MF_LEN + 4) step();
    check(link_state == 2'b10 || link_state == 2'b11, "R4", "restart after loss",
          64'(link_state), 64'h2);
    en = 1'b0;
    step();
    check(link_state == 2'b00 && lane_ctrl == '0 && link_rst, "R1", "disable resets",
          64'(link_state), 64'h0);
    repeat (3) step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule